// File: doc/BRIEF.md
# Always-On Seconds Counter with Alarm Compare

This block is a real-time counter meant for a slow always-on domain. It holds a 47-bit count. The upper 32 bits are whole seconds and the lower 15 bits are a fraction that advances once per 32.768 kHz tick. A seconds alarm compare raises a flag when the seconds word reaches a programmed value. Software reaches the counter, alarm, control, status and interrupt-enable registers over a simple 32-bit register bus clocked by the fast clock `clk`. The slow tick arrives as `tick_i`, a one-cycle strobe on `clk` that marks each rising edge of the slow clock.

Writes to most registers do not take effect at once. They are held in a single pending slot and committed on the third slow tick after they are accepted. While the slot is full a busy flag is high, and a completion flag is set when the write commits. Software polls that flag or takes an interrupt on it, and any read of the status word clears it. The interrupt-enable register is the one exception: it updates on the next fast clock edge. After power-up the counter is invalid and has never been loaded, so it stays frozen until software clears the not-valid flag, sets the enable bit and writes the seconds word.

Top module: `lp_sec_counter`

## Requirements
- R1: After reset the seconds, fraction, alarm, control and interrupt-enable registers read 0, `irq_o` is 0, and status reads 0x202: not-valid (bit 1) and write-next (bit 9) are set, and every other bit is clear.
- R2: The 15-bit fraction (offset 0x04, bits [14:0]) increments on every `tick_i` while control bit 3 (offset 0x10) is 1, the seconds word has been loaded and not-valid is 0. On the wrap from 0x7FFF to 0 the seconds word (offset 0x00) increments.
- R3: The fraction and seconds words hold while not-valid is set or while the seconds word has never been written since reset, even with control bit 3 set.
- R4: A bus write to any offset other than 0x18, accepted while status bit 10 (write busy) is 0, sets bit 10 on the next clock. It takes effect on the third `tick_i` after acceptance, and on that edge bit 10 clears and bit 8 (write complete) sets. Bit 9 (write next) reads as the inverse of bit 10.
- R5: Such a write that arrives while bit 10 is 1 is discarded and sets status bit 7 (write error) on the next clock.
- R6: Any bus read of status (offset 0x14) clears bit 8 on that edge, unless a write completes on the same edge, in which case bit 8 is 1.
- R7: A write to offset 0x18 stores data bits 9, 8, 7 and 4 on the next clock, reads back at those positions, and neither sets write busy nor write complete.
- R8: Status bit 4 (alarm) sets on the edge where the seconds word changes to a value equal to the alarm seconds (offset 0x08). Offset 0x0C (alarm fraction) always reads 0.
- R9: A committed write to status clears each of bits 7, 4, 1 and 0 whose data bit is 1. An alarm or write error raised on the same edge wins over the clear.
- R10: `irq_o` is 1 exactly when some enable bit at offset 0x18 (9, 8, 7, 4) and the status flag at the same bit position are both 1.
- R11: A committed seconds write leaves the fraction unchanged, and a committed fraction write loads only data bits [14:0]. Neither word advances on the tick where one of them loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per slow-clock rising edge |
| sel_i | input | 1 | Bus access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after a status read that lands on the same edge as a write commit. A design that let the clear win would lose the completion flag, and the driver would wait until it timed out. It also issues a second write while the first is still pending and then reads back the old alarm value. A design that overwrote the pending slot would store the wrong alarm and never raise the error flag. The bench checks that the counter stays frozen after enable and not-valid are handled but before any seconds write, that the fraction wraps into the seconds word, and that the alarm fires only when the seconds word changes. A design that compared levels instead of changes would fire again right after software cleared the flag.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_SEC   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAC  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ASEC  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_AFRAC = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h18;
  localparam int B_EN  = 3;
  localparam int B_WBF = 10;
  localparam int B_WNF = 9;
  localparam int B_WCF = 8;
  localparam int B_WEF = 7;
  localparam int B_ALM = 4;
  localparam int B_NVF = 1;
  localparam int B_SVF = 0;
  localparam logic [DATA_W-1:0] IEN_MASK = 32'h0000_0390;
endpackage

// File: rtl/lpsc_wr_sync.sv
module lpsc_wr_sync #(
  parameter int TICKS  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              apply_o,
  output logic              reject_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [DATA_W-1:0] pdata_o
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic              busy_q, busy_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  assign accept   = req_i & ~busy_q;
  assign reject_o = req_i & busy_q;
  assign apply_o  = busy_q & tick_i & (cnt_q == LAST);
  assign busy_o   = busy_q;
  assign paddr_o  = addr_q;
  assign pdata_o  = data_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      addr_d = addr_i;
      data_d = data_i;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/lpsc_time_cnt.sv
module lpsc_time_cnt #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  ld_data_i,
  input  logic [SEC_W-1:0]  alm_sec_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              seeded_o,
  output logic              match_o
);
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              seed_q, seed_d;
  logic              carry;

  always_comb begin
    sec_d  = sec_q;
    frac_d = frac_q;
    seed_d = seed_q | ld_sec_i;
    carry  = 1'b0;
    if (ld_sec_i) begin
      sec_d = ld_data_i;
    end else if (ld_frac_i) begin
      frac_d = ld_data_i[FRAC_W-1:0];
    end else if (tick_i && run_i && seed_q) begin
      {carry, frac_d} = {1'b0, frac_q} + 1'b1;
      sec_d = sec_q + {{(SEC_W-1){1'b0}}, carry};
    end
  end

  assign match_o  = (sec_d != sec_q) && (sec_d == alm_sec_i);
  assign sec_o    = sec_q;
  assign frac_o   = frac_q;
  assign seeded_o = seed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
      seed_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      frac_q <= frac_d;
      seed_q <= seed_d;
    end
  end
endmodule

// File: rtl/lp_sec_counter.sv
module lp_sec_counter
  import lpsc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int FRAC_W     = 15,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              req, ien_wr, rd_stat;
  logic              busy, apply, reject;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata;
  logic              ap_sec, ap_frac, ap_asec, ap_ctrl, ap_stat;
  logic [SEC_W-1:0]  sec;
  logic [FRAC_W-1:0] frac;
  logic              seeded, match, run;

  logic [SEC_W-1:0]  asec_q, asec_d;
  logic [DATA_W-1:0] ien_q, ien_d;
  logic en_q, en_d, wcf_q, wcf_d, wef_q, wef_d;
  logic alm_q, alm_d, nvf_q, nvf_d, svf_q, svf_d;
  logic [DATA_W-1:0] stat;

  assign req     = sel_i & wr_i & (addr_i != OFS_IEN);
  assign ien_wr  = sel_i & wr_i & (addr_i == OFS_IEN);
  assign rd_stat = sel_i & ~wr_i & (addr_i == OFS_STAT);

  lpsc_wr_sync #(.TICKS(SYNC_TICKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req),
    .addr_i(addr_i), .data_i(wdata_i), .busy_o(busy), .apply_o(apply),
    .reject_o(reject), .paddr_o(paddr), .pdata_o(pdata)
  );

  assign ap_sec  = apply & (paddr == OFS_SEC);
  assign ap_frac = apply & (paddr == OFS_FRAC);
  assign ap_asec = apply & (paddr == OFS_ASEC);
  assign ap_ctrl = apply & (paddr == OFS_CTRL);
  assign ap_stat = apply & (paddr == OFS_STAT);
  assign run     = en_q & ~nvf_q;

  lpsc_time_cnt #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .ld_sec_i(ap_sec), .ld_frac_i(ap_frac), .ld_data_i(pdata[SEC_W-1:0]),
    .alm_sec_i(asec_q), .sec_o(sec), .frac_o(frac), .seeded_o(seeded),
    .match_o(match)
  );

  always_comb begin
    asec_d = ap_asec ? pdata[SEC_W-1:0] : asec_q;
    en_d   = ap_ctrl ? pdata[B_EN] : en_q;
    ien_d  = ien_wr ? (wdata_i & IEN_MASK) : ien_q;
    wcf_d  = (wcf_q & ~rd_stat) | apply;
    wef_d  = (wef_q & ~(ap_stat & pdata[B_WEF])) | reject;
    alm_d  = (alm_q & ~(ap_stat & pdata[B_ALM])) | match;
    nvf_d  = nvf_q & ~(ap_stat & pdata[B_NVF]);
    svf_d  = svf_q & ~(ap_stat & pdata[B_SVF]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asec_q <= '0;
      ien_q  <= '0;
      en_q   <= 1'b0;
      wcf_q  <= 1'b0;
      wef_q  <= 1'b0;
      alm_q  <= 1'b0;
      nvf_q  <= 1'b1;
      svf_q  <= 1'b0;
    end else begin
      asec_q <= asec_d;
      ien_q  <= ien_d;
      en_q   <= en_d;
      wcf_q  <= wcf_d;
      wef_q  <= wef_d;
      alm_q  <= alm_d;
      nvf_q  <= nvf_d;
      svf_q  <= svf_d;
    end
  end

  always_comb begin
    stat        = '0;
    stat[B_WBF] = busy;
    stat[B_WNF] = ~busy;
    stat[B_WCF] = wcf_q;
    stat[B_WEF] = wef_q;
    stat[B_ALM] = alm_q;
    stat[B_NVF] = nvf_q;
    stat[B_SVF] = svf_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_SEC:   rdata_o = DATA_W'(sec);
      OFS_FRAC:  rdata_o = DATA_W'(frac);
      OFS_ASEC:  rdata_o = DATA_W'(asec_q);
      OFS_AFRAC: rdata_o = '0;
      OFS_CTRL:  rdata_o[B_EN] = en_q;
      OFS_STAT:  rdata_o = stat;
      OFS_IEN:   rdata_o = ien_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = |(ien_q & stat & IEN_MASK);
endmodule

// File: rtl/lpsc_checker.sv
module lpsc_checker #(
  parameter int FRAC_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic [4:0]        addr_i,
  input logic              busy,
  input logic              apply,
  input logic              wcf_q,
  input logic              wef_q,
  input logic              nvf_q,
  input logic              seeded,
  input logic [FRAC_W-1:0] frac
);
  logic sync_wr, ien_w, st_rd;
  assign sync_wr = sel_i & wr_i & (addr_i != 5'h18);
  assign ien_w   = sel_i & wr_i & (addr_i == 5'h18);
  assign st_rd   = sel_i & ~wr_i & (addr_i == 5'h14);

  assert_busy_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_wr && !busy) |=> busy);
  assert_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick_i));
  assert_err_on_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wef_q) |-> $past(sync_wr && busy));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !apply) |=> !wcf_q);
  assert_ien_no_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_w && !busy) |=> !busy);
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((nvf_q || !seeded) && !apply) |=> $stable(frac));
endmodule

bind lp_sec_counter lpsc_checker #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
  .addr_i(addr_i), .busy(busy), .apply(apply), .wcf_q(wcf_q), .wef_q(wef_q),
  .nvf_q(nvf_q), .seeded(seeded), .frac(frac)
);

// File: tb/lp_sec_counter_tb.sv
module lp_sec_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [4:0]  addr_i = 5'h0;
  logic [31:0] wdata_i = 32'h0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  lp_sec_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // slow tick: one strobe every 4 fast cycles
  int tphase = 0;
  initial forever begin
    @(posedge clk); #2;
    tphase = (tphase + 1) % 4;
    tick_i = (tphase == 0);
  end

  // behavioural reference model
  bit [31:0] m_sec, m_alm, m_ier, m_pdata;
  int        m_frac, m_cnt;
  bit [4:0]  m_paddr;
  bit m_en, m_seed, m_busy, m_wcf, m_wef, m_caf, m_nvf, m_svf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_alm = 0; m_ier = 0; m_pdata = 0; m_frac = 0; m_cnt = 0;
      m_paddr = 0; m_en = 0; m_seed = 0; m_busy = 0; m_wcf = 0; m_wef = 0;
      m_caf = 0; m_nvf = 1; m_svf = 0;
    end else begin
      bit req, app, running, hit;
      bit [31:0] old_sec;
      req = sel_i && wr_i && addr_i != 5'h18;
      app = m_busy && tick_i && m_cnt == 2;
      running = m_en && m_seed && !m_nvf;
      old_sec = m_sec;
      if (app && m_paddr == 5'h00) begin m_sec = m_pdata; m_seed = 1; end
      else if (app && m_paddr == 5'h04) m_frac = int'(m_pdata & 32'h7FFF);
      else if (tick_i && running) begin
        m_frac++;
        if (m_frac == 32768) begin m_frac = 0; m_sec++; end
      end
      hit = (m_sec != old_sec) && (m_sec == m_alm);
      if (sel_i && !wr_i && addr_i == 5'h14) m_wcf = 0;
      if (app) begin
        m_wcf = 1;
        if (m_paddr == 5'h08) m_alm = m_pdata;
        if (m_paddr == 5'h10) m_en = m_pdata[3];
        if (m_paddr == 5'h14) begin
          if (m_pdata[7]) m_wef = 0;
          if (m_pdata[4]) m_caf = 0;
          if (m_pdata[1]) m_nvf = 0;
          if (m_pdata[0]) m_svf = 0;
        end
      end
      if (req && m_busy) m_wef = 1;
      if (hit) m_caf = 1;
      if (sel_i && wr_i && addr_i == 5'h18) m_ier = wdata_i & 32'h390;
      if (req && !m_busy) begin
        m_busy = 1; m_cnt = 0; m_paddr = addr_i; m_pdata = wdata_i;
      end else if (m_busy && tick_i) begin
        if (m_cnt == 2) m_busy = 0; else m_cnt++;
      end
    end
  end

  function automatic bit [31:0] m_stat();
    return {21'b0, m_busy, !m_busy, m_wcf, m_wef, 2'b0, m_caf, 2'b0, m_nvf, m_svf};
  endfunction

  function automatic bit [31:0] m_read(bit [4:0] a);
    case (a)
      5'h00: return m_sec;
      5'h04: return 32'(m_frac);
      5'h08: return m_alm;
      5'h10: return {28'b0, m_en, 3'b0};
      5'h14: return m_stat();
      5'h18: return m_ier;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string area(bit [4:0] a);
    case (a)
      5'h00, 5'h04: return "R2";
      5'h08, 5'h0C: return "R8";
      5'h10: return "R4";
      5'h14: return "R6";
      default: return "R7";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [31:0] e;
      bit ei;
      e  = m_read(addr_i);
      ei = |(m_ier & m_stat());
      vectors++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s: addr %h rdata %h expected %h", area(addr_i), addr_i, rdata_o, e);
      end
      if (irq_o !== ei) begin
        errors++;
        $display("FAIL R10: irq %b expected %b", irq_o, ei);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(bit [4:0] a, bit [31:0] d);
    @(posedge clk); #2;
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #2;
    sel_i = 0; wr_i = 0;
  endtask

  // read with a directed check against a given expectation
  task automatic bus_rd(bit [4:0] a, string tag, bit use_model, bit [31:0] exp);
    @(posedge clk); #2;
    sel_i = 1; wr_i = 0; addr_i = a;
    @(negedge clk);
    chk(tag, rdata_o, use_model ? m_read(a) : exp);
    @(posedge clk); #2;
    sel_i = 0;
  endtask

  task automatic settle();
    repeat (18) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    bus_rd(5'h00, "R1 seconds", 0, 32'h0);
    bus_rd(5'h14, "R1 status", 0, 32'h202);
    bus_rd(5'h18, "R1 ien", 0, 32'h0);
    @(negedge clk); chk("R1 irq", {31'b0, irq_o}, 32'h0);
    // R4 enable write, busy then complete
    bus_wr(5'h10, 32'h8);
    bus_rd(5'h14, "R4 busy", 0, 32'h402);
    settle();
    bus_rd(5'h14, "R4 complete", 0, 32'h302);
    bus_rd(5'h14, "R6 cleared by read", 0, 32'h202);
    // R9 clear not-valid
    bus_wr(5'h14, 32'h2);
    settle();
    bus_rd(5'h14, "R9 nvf cleared", 0, 32'h300);
    // R3 frozen until seconds written
    repeat (40) @(posedge clk);
    bus_rd(5'h04, "R3 fraction held", 0, 32'h0);
    bus_rd(5'h00, "R3 seconds held", 0, 32'h0);
    // R11 loads
    bus_wr(5'h04, 32'hABCD_7FF0);
    settle();
    bus_rd(5'h04, "R11 fraction load", 0, 32'h7FF0);
    bus_wr(5'h00, 32'h6);
    settle();
    bus_rd(5'h04, "R11 fraction kept", 1, 32'h0);
    // R8 alarm via wrap (R2 carry)
    bus_wr(5'h08, 32'h7);
    settle();
    bus_wr(5'h18, 32'h10);
    repeat (80) @(posedge clk);
    bus_rd(5'h00, "R2 carry into seconds", 0, 32'h7);
    bus_rd(5'h14, "R8 alarm flag", 1, 32'h0);
    @(negedge clk); chk("R10 alarm irq", {31'b0, irq_o}, 32'h1);
    bus_rd(5'h0C, "R8 alarm fraction zero", 0, 32'h0);
    // R5 collision
    bus_wr(5'h08, 32'd100);
    bus_wr(5'h08, 32'd200);
    settle();
    bus_rd(5'h08, "R5 first write kept", 0, 32'd100);
    bus_rd(5'h14, "R5 error flag", 1, 32'h0);
    // R7 ien immediate, no busy
    bus_wr(5'h18, 32'hFFFF_FFFF);
    bus_rd(5'h18, "R7 ien mask", 0, 32'h390);
    bus_rd(5'h14, "R7 no busy", 1, 32'h0);
    // R9 clear error and alarm
    bus_wr(5'h14, 32'h90);
    settle();
    bus_rd(5'h14, "R9 cleared", 1, 32'h0);
    // R6 completion colliding with continuous status reads
    bus_wr(5'h10, 32'h8);
    @(posedge clk); #2;
    sel_i = 1; wr_i = 0; addr_i = 5'h14;
    repeat (20) @(posedge clk);
    #2 sel_i = 0;
    bus_rd(5'h14, "R6 after collision", 1, 32'h0);
    // R2 hold when disabled
    bus_wr(5'h10, 32'h0);
    settle();
    bus_rd(5'h04, "R2 disabled hold", 1, 32'h0);
    repeat (20) @(posedge clk);
    bus_rd(5'h04, "R2 still held", 1, 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule